// File: doc/BRIEF.md
# 4:2:2 Chroma Output Formatter

This block sits at the pixel output of a video front end and selects the width of the pixel bus. Each pixel clock it takes one pixel made of three 8-bit channels (red lane carrying V, green lane carrying Y, blue lane carrying U) and a line sync. In full-rate mode all three channels leave on their own output ports. In the reduced mode only 16 lines carry data: luma stays on the green port, the red port carries U and V in turn, and the blue port has its enable dropped so an external pad can float it.

Chroma is thinned by plain selection: the even pixels of a line give their U sample and the odd pixels give their V sample. No averaging takes place. The U/V phase restarts at the leading edge of every line sync. The mode pin is sampled only on that edge, so one line is never split between the two formats. Every output is registered with one pixel-clock cycle of latency in both modes.

Top module: `chroma_packer`

## Requirements
- R1: While reset is asserted, all three output buses are zero and all three enables are low. After reset the block is in full-rate (4:4:4) mode until the first line-sync leading edge.
- R2: When the mode pin is 1 (4:4:4) at the active line edge, out_red, out_grn and out_blu equal in_red, in_grn and in_blu, and en_red, en_grn and en_blu are all high.
- R3: When the mode pin is 0 (4:2:2) at the active line edge, out_grn carries in_grn (Y) and en_grn is high.
- R4: In 4:2:2 mode, out_red carries in_blu (U) on pixels 0, 2, 4… of a line and in_red (V) on pixels 1, 3, 5…. Pixel 0 is the pixel presented in the same cycle as the line-sync leading edge.
- R5: In 4:2:2 mode, en_blu is low and out_blu is zero, so 16 lines carry data. en_red stays high.
- R6: The U/V phase returns to U at every line-sync leading edge, whatever the pixel count of the previous line.
- R7: fmt_sel is sampled only in the cycle of a line-sync leading edge. A change at any other time has no effect on the outputs until the next leading edge.
- R8: Every output reflects the inputs of the previous rising pix_clk edge, with the same one-cycle latency in both modes.
- R9: A leading edge is a 0-to-1 change of line_sync (with the default polarity). Holding line_sync high causes no further phase restart.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 1 | 0 = 4:2:2, 1 = 4:4:4, taken at line-sync leading edge |
| line_sync | input | 1 | Horizontal line sync |
| in_red | input | 8 | V channel |
| in_grn | input | 8 | Y channel |
| in_blu | input | 8 | U channel |
| out_red | output | 8 | V, or alternating U/V in 4:2:2 |
| out_grn | output | 8 | Y |
| out_blu | output | 8 | U, zero in 4:2:2 |
| en_red | output | 1 | Drive enable for out_red |
| en_grn | output | 1 | Drive enable for out_grn |
| en_blu | output | 1 | Drive enable for out_blu, low in 4:2:2 |

## Verification
The bench sends lines of odd length. A formatter that let the phase run freely would then open the next line with V. It toggles fmt_sel in the middle of a line, which catches a design that switches format at once and splits the line. It holds line_sync high for several cycles, so that a level-sensitive restart would send U twice in a row. Across long random traffic it checks that U and V are never swapped, that the blue enable tracks the format, and that the latency stays at one cycle in both modes.

// File: rtl/chroma_packer_pkg.sv
package chroma_packer_pkg;
   typedef enum logic {FMT_422 = 1'b0, FMT_444 = 1'b1} fmt_e;
   typedef enum logic {PH_U = 1'b0, PH_V = 1'b1} phase_e;
   localparam int unsigned NUM_LANES = 3;
   localparam int unsigned LANE_RED  = 0;
   localparam int unsigned LANE_GRN  = 1;
   localparam int unsigned LANE_BLU  = 2;
endpackage

// File: rtl/line_edge.sv
module line_edge #(
   parameter bit SYNC_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic lead
);
   logic act;
   logic act_q;

   generate
      if (SYNC_HIGH) begin : g_high
         assign act = sync_in;
      end else begin : g_low
         assign act = ~sync_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign lead = act & ~act_q;
endmodule

// File: rtl/line_ctl.sv
module line_ctl
   import chroma_packer_pkg::*;
#(
   parameter bit RST_444 = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   lead,
   input  logic   fmt_sel,
   output fmt_e   cur_fmt,
   output phase_e cur_ph
);
   localparam fmt_e RST_FMT = RST_444 ? FMT_444 : FMT_422;

   fmt_e   fmt_q;
   phase_e ph_q;

   always_comb begin
      cur_fmt = lead ? fmt_e'(fmt_sel) : fmt_q;
      cur_ph  = lead ? PH_U : ph_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= RST_FMT;
         ph_q  <= PH_U;
      end else begin
         fmt_q <= cur_fmt;
         ph_q  <= (cur_ph == PH_U) ? PH_V : PH_U;
      end
   end
endmodule

// File: rtl/lane_select.sv
module lane_select
   import chroma_packer_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  fmt_e                            cur_fmt,
   input  phase_e                          cur_ph,
   input  logic [W-1:0]                    in_red,
   input  logic [W-1:0]                    in_grn,
   input  logic [W-1:0]                    in_blu,
   output logic [NUM_LANES-1:0][W-1:0]     nxt_data,
   output logic [NUM_LANES-1:0]            nxt_en
);
   always_comb begin
      nxt_data[LANE_GRN] = in_grn;
      nxt_en[LANE_GRN]   = 1'b1;
      nxt_en[LANE_RED]   = 1'b1;
      if (cur_fmt == FMT_444) begin
         nxt_data[LANE_RED] = in_red;
         nxt_data[LANE_BLU] = in_blu;
         nxt_en[LANE_BLU]   = 1'b1;
      end else begin
         nxt_data[LANE_RED] = (cur_ph == PH_U) ? in_blu : in_red;
         nxt_data[LANE_BLU] = '0;
         nxt_en[LANE_BLU]   = 1'b0;
      end
   end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
   parameter int unsigned W     = 8,
   parameter int unsigned LANES = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0][W-1:0] nxt_data,
   input  logic [LANES-1:0]        nxt_en,
   output logic [LANES-1:0][W-1:0] q_data,
   output logic [LANES-1:0]        q_en
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_data[i] <= '0;
               q_en[i]   <= 1'b0;
            end else begin
               q_data[i] <= nxt_data[i];
               q_en[i]   <= nxt_en[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/chroma_packer.sv
module chroma_packer
   import chroma_packer_pkg::*;
#(
   parameter int unsigned CH_W      = 8,
   parameter bit          SYNC_HIGH = 1'b1,
   parameter bit          RST_444   = 1'b1
) (
   input  logic            pix_clk,
   input  logic            rst_n,
   input  logic            fmt_sel,
   input  logic            line_sync,
   input  logic [CH_W-1:0] in_red,
   input  logic [CH_W-1:0] in_grn,
   input  logic [CH_W-1:0] in_blu,
   output logic [CH_W-1:0] out_red,
   output logic [CH_W-1:0] out_grn,
   output logic [CH_W-1:0] out_blu,
   output logic            en_red,
   output logic            en_grn,
   output logic            en_blu
);
   generate
      if (CH_W < 1 || CH_W > 16) begin : g_bad_width
         $error("chroma_packer: CH_W must lie in 1..16");
      end
   endgenerate

   logic                            lead;
   fmt_e                            cur_fmt;
   phase_e                          cur_ph;
   logic [NUM_LANES-1:0][CH_W-1:0]  nxt_data;
   logic [NUM_LANES-1:0]            nxt_en;
   logic [NUM_LANES-1:0][CH_W-1:0]  q_data;
   logic [NUM_LANES-1:0]            q_en;

   line_edge #(.SYNC_HIGH(SYNC_HIGH)) u_edge (
      .clk(pix_clk), .rst_n(rst_n), .sync_in(line_sync), .lead(lead)
   );

   line_ctl #(.RST_444(RST_444)) u_ctl (
      .clk(pix_clk), .rst_n(rst_n), .lead(lead), .fmt_sel(fmt_sel),
      .cur_fmt(cur_fmt), .cur_ph(cur_ph)
   );

   lane_select #(.W(CH_W)) u_sel (
      .cur_fmt(cur_fmt), .cur_ph(cur_ph),
      .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
      .nxt_data(nxt_data), .nxt_en(nxt_en)
   );

   out_stage #(.W(CH_W), .LANES(NUM_LANES)) u_out (
      .clk(pix_clk), .rst_n(rst_n), .nxt_data(nxt_data), .nxt_en(nxt_en),
      .q_data(q_data), .q_en(q_en)
   );

   assign out_red = q_data[LANE_RED];
   assign out_grn = q_data[LANE_GRN];
   assign out_blu = q_data[LANE_BLU];
   assign en_red  = q_en[LANE_RED];
   assign en_grn  = q_en[LANE_GRN];
   assign en_blu  = q_en[LANE_BLU];
endmodule

// File: rtl/chroma_packer_chk.sv
module chroma_packer_chk #(
   parameter int unsigned W         = 8,
   parameter bit          SYNC_HIGH = 1'b1
) (
   input logic         pix_clk,
   input logic         rst_n,
   input logic         line_sync,
   input logic [W-1:0] in_red,
   input logic [W-1:0] in_grn,
   input logic [W-1:0] in_blu,
   input logic [W-1:0] out_red,
   input logic [W-1:0] out_grn,
   input logic [W-1:0] out_blu,
   input logic         en_red,
   input logic         en_grn,
   input logic         en_blu
);
   logic [1:0] armed_q;
   logic       act_q;
   logic       act_w;
   logic       lead_w;

   assign act_w  = SYNC_HIGH ? line_sync : ~line_sync;
   assign lead_w = act_w & ~act_q;

   always_ff @(posedge pix_clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 2'b00;
         act_q   <= 1'b0;
      end else begin
         armed_q <= {armed_q[0], 1'b1};
         act_q   <= act_w;
      end
   end

   p_luma_r3: assert property (@(posedge pix_clk) disable iff (!rst_n)
      armed_q[0] |-> out_grn == $past(in_grn));

   p_pass_r2: assert property (@(posedge pix_clk) disable iff (!rst_n)
      (armed_q[0] && en_blu) |-> (out_red == $past(in_red) && out_blu == $past(in_blu)));

   p_blue_off_r5: assert property (@(posedge pix_clk) disable iff (!rst_n)
      (armed_q[0] && !en_blu) |-> out_blu == '0);

   p_chroma_src_r4: assert property (@(posedge pix_clk) disable iff (!rst_n)
      (armed_q[0] && !en_blu) |-> (out_red == $past(in_red) || out_red == $past(in_blu)));

   p_mode_hold_r7: assert property (@(posedge pix_clk) disable iff (!rst_n)
      (armed_q[1] && !$past(lead_w)) |-> $stable(en_blu));

   p_enables_r8: assert property (@(posedge pix_clk) disable iff (!rst_n)
      armed_q[0] |-> (en_red && en_grn));
endmodule

bind chroma_packer chroma_packer_chk #(.W(CH_W), .SYNC_HIGH(SYNC_HIGH)) u_chk (
   .pix_clk(pix_clk), .rst_n(rst_n), .line_sync(line_sync),
   .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
   .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
   .en_red(en_red), .en_grn(en_grn), .en_blu(en_blu)
);

// File: tb/chroma_packer_bench.sv
`timescale 1ns/1ps
module chroma_packer_bench;
   logic       pix_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       fmt_sel = 1'b0;
   logic       line_sync = 1'b0;
   logic [7:0] in_red = '0, in_grn = '0, in_blu = '0;
   logic [7:0] out_red, out_grn, out_blu;
   logic       en_red, en_grn, en_blu;

   int unsigned n_run  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   bit m_prev  = 1'b0;
   bit m_fmt   = 1'b1;
   bit m_phase = 1'b0;

   always #4 pix_clk = ~pix_clk;

   chroma_packer u_chroma_packer (
      .pix_clk(pix_clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .line_sync(line_sync),
      .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
      .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
      .en_red(en_red), .en_grn(en_grn), .en_blu(en_blu)
   );

   task automatic chk(string tag, string ctx, string fld, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s %s: got %0h expected %0h", tag, ctx, fld, act, exp);
      end
   endtask

   task automatic step(bit hs, bit fm, logic [7:0] r, logic [7:0] g, logic [7:0] b, string ctx);
      bit lead, cm, cp;
      logic [7:0] ea, eg, eb;
      bit xa, xg, xb;
      lead = hs && !m_prev;
      cm   = lead ? fm : m_fmt;
      cp   = lead ? 1'b0 : m_phase;
      eg = g; xa = 1'b1; xg = 1'b1;
      if (cm) begin ea = r; eb = b; xb = 1'b1; end
      else begin ea = cp ? r : b; eb = 8'h00; xb = 1'b0; end
      m_prev = hs; m_fmt = cm; m_phase = !cp;
      line_sync = hs; fmt_sel = fm; in_red = r; in_grn = g; in_blu = b;
      @(negedge pix_clk);
      chk(cm ? "R2" : "R4", ctx, "out_red", out_red, ea);
      chk(cm ? "R2" : "R3", ctx, "out_grn", out_grn, eg);
      chk(cm ? "R2" : "R5", ctx, "out_blu", out_blu, eb);
      chk("R8", ctx, "en_red", {7'd0, en_red}, {7'd0, xa});
      chk("R8", ctx, "en_grn", {7'd0, en_grn}, {7'd0, xg});
      chk(cm ? "R2" : "R5", ctx, "en_blu", {7'd0, en_blu}, {7'd0, xb});
   endtask

   task automatic rnd_step(bit hs, bit fm, string ctx);
      step(hs, fm, 8'($urandom), 8'($urandom), 8'($urandom), ctx);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge pix_clk);
      in_red = 8'hAA; in_grn = 8'h55; in_blu = 8'h33; line_sync = 1'b1;
      @(negedge pix_clk);
      chk("R1", "reset", "out_red", out_red, 8'h00);
      chk("R1", "reset", "out_grn", out_grn, 8'h00);
      chk("R1", "reset", "out_blu", out_blu, 8'h00);
      chk("R1", "reset", "enables", {5'd0, en_red, en_grn, en_blu}, 8'h00);
      line_sync = 1'b0;
      rst_n = 1'b1;
      // R1: default mode is 4:4:4 before any edge, even with fmt_sel = 0
      for (int i = 0; i < 4; i++) rnd_step(1'b0, 1'b0, "R1 default");
      // R4: odd-length 4:2:2 line
      rnd_step(1'b1, 1'b0, "R4 line start");
      for (int i = 0; i < 4; i++) rnd_step(1'b0, 1'b0, "R4 odd line");
      // R6: restart after odd count
      rnd_step(1'b1, 1'b0, "R6 restart");
      for (int i = 0; i < 3; i++) rnd_step(1'b0, 1'b0, "R6 after");
      // R7: mid-line mode change ignored
      for (int i = 0; i < 5; i++) rnd_step(1'b0, 1'b1, "R7 mid-line");
      rnd_step(1'b1, 1'b1, "R7 applied");
      for (int i = 0; i < 3; i++) rnd_step(1'b0, 1'b0, "R7 mid-line back");
      rnd_step(1'b1, 1'b0, "R7 back to 422");
      // R9: sync held high, no extra restart
      for (int i = 0; i < 6; i++) rnd_step(1'b1, 1'b0, "R9 held high");
      for (int i = 0; i < 2; i++) rnd_step(1'b0, 1'b0, "R9 release");
      // random lines
      for (int ln = 0; ln < 150; ln++) begin
         bit fm;
         int len;
         int hw;
         fm  = 1'($urandom);
         len = 2 + int'($urandom % 17);
         hw  = 1 + int'($urandom % 3);
         for (int i = 0; i < len; i++)
            rnd_step(i < hw, (i == 0) ? fm : 1'($urandom), "R8 random");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule